// File: doc/BRIEF.md
# Adaptive Noise Floor Energy Detector

This block watches a stream of received signal strength samples, one per sample strobe. Each sample carries an antenna select bit and a flag that says whether a modulated signal is currently being received. For each of two antennas it learns a noise floor. The floor is the average of the most recent 256 samples that arrived while no signal was present. A floor value is available from the first such sample onward, and it keeps adapting to the environment after that.

On every accepted strobe the block raises or clears an energy-detect flag. The flag is set when the sample reaches a threshold. That threshold is either a fixed programmed level or a programmed margin added to the learned floor of the antenna that produced the sample. The flag always feeds channel assessment. When squelch is enabled, the flag also gates the start of acquisition, so weak signals are not acquired.

Turning the receiver off clears the flag. It does not disturb the learned floors, so they are ready again when the receiver comes back on. Configuration uses a small parallel write bus.

Top module: `nf_energy_detect`

## Requirements
- R1: After a synchronous active-low reset, `ed_flag` is 0, `acq_allow` is 1, both floors read 0, and all configuration fields are 0.
- R2: On a clock edge with `smp_valid` and `rx_en` both high, `ed_flag` becomes 1 exactly when `smp_rssi` is greater than or equal to the selected threshold. In that comparison the threshold uses the floors as they stood before this sample. `ed_flag` holds its value on edges where `rx_en` is high and `smp_valid` is low.
- R3: When the mode bit (address 2, bit 0) is 0, the threshold is the absolute level written at address 0.
- R4: When the mode bit is 1, the threshold is the floor of the antenna selected by `smp_ant`, plus the margin written at address 1. The sum saturates at 255 and never wraps.
- R5: A sample updates the floor of antenna `smp_ant` only when `smp_valid` and `rx_en` are high and `smp_sig` is low. The floor of the other antenna does not change.
- R6: Once an antenna has collected 256 or more qualifying samples, its floor equals the integer mean of its last 256 qualifying samples, rounded down. Each new sample replaces the oldest one.
- R7: While an antenna holds n qualifying samples, with 1 <= n < 256, its floor is the sum of those samples shifted right by floor(log2(n)), capped at 255. With n = 0 the floor is 0.
- R8: While `rx_en` is low, samples are ignored, both floors keep their values, and `ed_flag` is 0 from the next edge onward.
- R9: `acq_allow` equals `ed_flag` when the squelch bit (address 2, bit 1) is 1, and it is 1 otherwise.
- R10: A write with `cfg_we` high stores `cfg_wdata` into the field selected by `cfg_addr`. Address 0 holds the absolute level, address 1 the margin, and address 2 the control bits. A write to address 3 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Configuration field select |
| cfg_wdata | input | 8 | Configuration write data |
| rx_en | input | 1 | Receiver enable |
| smp_valid | input | 1 | Sample strobe |
| smp_ant | input | 1 | Antenna that produced the sample |
| smp_sig | input | 1 | Modulated signal present during the sample |
| smp_rssi | input | 8 | Signal strength, unsigned dB code |
| ed_flag | output | 1 | Energy detect |
| acq_allow | output | 1 | Acquisition permitted (squelch result) |
| floor_a0 | output | 8 | Learned floor, antenna 0 |
| floor_a1 | output | 8 | Learned floor, antenna 1 |

## Verification
`ed_flag` is registered, so a strobe presented before an edge shows its result just after that edge. The floors are combinational from registered sums and counts, so they also reflect a qualifying sample right after the edge that takes it in. `acq_allow` follows `ed_flag` and the squelch bit without further delay. The bench drives every input on the falling edge and compares all outputs on the following falling edge. For the threshold it uses the model floor from before the sample, and for the floor outputs the model floor from after it. Configuration writes take effect on the edge that captures them.

// File: rtl/nfed_pkg.sv
// Shared parameters and helpers for the noise floor energy detector.
// Assumes RSSI is an unsigned dB code whose width is set by RSSI_W.
package nfed_pkg;
    localparam int RSSI_W = 8;
    localparam int NUM_ANT = 2;

    // Configuration fields held by the register bank.
    typedef struct packed {
        logic [RSSI_W-1:0] abs_level;
        logic [RSSI_W-1:0] margin;
        logic              rel_mode;
        logic              squelch_en;
    } nfed_cfg_t;

    // Index of the highest set bit (0 for an input of 0).
    function automatic int unsigned msb_index(input logic [15:0] v);
        int unsigned r;
        r = 0;
        for (int i = 0; i < 16; i++) begin
            if (v[i]) r = i;
        end
        return r;
    endfunction
endpackage

// File: rtl/nfed_cfg.sv
// Configuration register bank: a write-only parallel bus into three fields.
// Assumes a single write port; unmapped addresses are discarded.
module nfed_cfg
    import nfed_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [1:0]        addr,
    input  logic [RSSI_W-1:0] wdata,
    output nfed_cfg_t         cfg
);
    // Store written data into the addressed field.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg <= '0;
        end else if (we) begin
            case (addr)
                2'd0: cfg.abs_level <= wdata;
                2'd1: cfg.margin    <= wdata;
                2'd2: begin
                    cfg.rel_mode   <= wdata[0];
                    cfg.squelch_en <= wdata[1];
                end
                default: ;
            endcase
        end
    end

    AST_ADDR3_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == 2'd3) |=> $stable(cfg)); // R10
endmodule

// File: rtl/nfed_floor_bank.sv
// One antenna's noise floor estimator: a circular buffer of DEPTH samples
// with a running sum. Before the buffer fills, the sum is divided by the
// largest power of two not above the count. Assumes DEPTH is a power of two.
module nfed_floor_bank
    import nfed_pkg::*;
#(
    parameter int DEPTH = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [RSSI_W-1:0] din,
    output logic [RSSI_W-1:0] floor_val
);
    localparam int AW    = $clog2(DEPTH);
    localparam int SUM_W = RSSI_W + AW;
    localparam int CNT_W = AW + 1;

    logic [RSSI_W-1:0] mem [DEPTH];
    logic [AW-1:0]     ptr;
    logic [CNT_W-1:0]  count;
    logic [SUM_W-1:0]  sum;
    logic              full;
    logic [SUM_W-1:0]  quot;

    assign full = (count == CNT_W'(DEPTH));

    // Buffer storage: write the new sample over the oldest slot.
    always_ff @(posedge clk) begin
        if (push) mem[ptr] <= din;
    end

    // Running sum, fill count and write pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr   <= '0;
            count <= '0;
            sum   <= '0;
        end else if (push) begin
            ptr <= ptr + 1'b1;
            if (full) begin
                sum <= sum + SUM_W'(din) - SUM_W'(mem[ptr]);
            end else begin
                sum   <= sum + SUM_W'(din);
                count <= count + 1'b1;
            end
        end
    end

    // Floor: sum over the power-of-two count, capped to the RSSI range.
    always_comb begin
        quot = sum >> msb_index(16'(count));
        if (quot > SUM_W'({RSSI_W{1'b1}})) floor_val = '1;
        else                               floor_val = quot[RSSI_W-1:0];
    end

    AST_COUNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(DEPTH)); // R6
    AST_COUNT_GROW: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !full) |=> count == $past(count) + 1'b1); // R7
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !push |=> ($stable(sum) && $stable(count))); // R5
endmodule

// File: rtl/nfed_compare.sv
// Threshold selection and registered energy-detect flag.
// Assumes the floors presented are those in effect before the current strobe.
module nfed_compare
    import nfed_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  nfed_cfg_t         cfg,
    input  logic              rx_en,
    input  logic              smp_valid,
    input  logic              smp_ant,
    input  logic [RSSI_W-1:0] smp_rssi,
    input  logic [RSSI_W-1:0] floor_a0,
    input  logic [RSSI_W-1:0] floor_a1,
    output logic              ed_flag
);
    logic [RSSI_W-1:0] floor_sel;
    logic [RSSI_W:0]   rel_sum;
    logic [RSSI_W-1:0] thr;

    // Pick the active antenna's floor and form the saturating threshold.
    always_comb begin
        floor_sel = smp_ant ? floor_a1 : floor_a0;
        rel_sum   = {1'b0, floor_sel} + {1'b0, cfg.margin};
        if (!cfg.rel_mode)     thr = cfg.abs_level;
        else if (rel_sum[RSSI_W]) thr = '1;
        else                   thr = rel_sum[RSSI_W-1:0];
    end

    // Update the flag on each accepted strobe; clear it while disabled.
    always_ff @(posedge clk) begin
        if (!rst_n)         ed_flag <= 1'b0;
        else if (!rx_en)    ed_flag <= 1'b0;
        else if (smp_valid) ed_flag <= (smp_rssi >= thr);
    end

    AST_REL_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        cfg.rel_mode |-> thr >= floor_sel); // R4
    AST_ED_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> !ed_flag); // R8
    AST_ED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_en && !smp_valid) |=> $stable(ed_flag)); // R2
endmodule

// File: rtl/nf_energy_detect.sv
// Top of the adaptive noise floor energy detector: configuration bank,
// one floor estimator per antenna, and the threshold comparator.
// Assumes one sample per strobe; floors survive receiver disable.
module nf_energy_detect
    import nfed_pkg::*;
#(
    parameter int DEPTH = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_addr,
    input  logic [7:0]        cfg_wdata,
    input  logic              rx_en,
    input  logic              smp_valid,
    input  logic              smp_ant,
    input  logic              smp_sig,
    input  logic [7:0]        smp_rssi,
    output logic              ed_flag,
    output logic              acq_allow,
    output logic [7:0]        floor_a0,
    output logic [7:0]        floor_a1
);
    nfed_cfg_t         cfg;
    logic [RSSI_W-1:0] floors [NUM_ANT];

    nfed_cfg u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .addr  (cfg_addr),
        .wdata (cfg_wdata),
        .cfg   (cfg)
    );

    for (genvar a = 0; a < NUM_ANT; a++) begin : g_ant
        logic push;
        // Accept only signal-free samples for this antenna while enabled.
        assign push = rx_en && smp_valid && !smp_sig && (smp_ant == 1'(a));
        nfed_floor_bank #(.DEPTH(DEPTH)) u_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .push      (push),
            .din       (smp_rssi),
            .floor_val (floors[a])
        );
    end

    assign floor_a0 = floors[0];
    assign floor_a1 = floors[1];

    nfed_compare u_cmp (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg       (cfg),
        .rx_en     (rx_en),
        .smp_valid (smp_valid),
        .smp_ant   (smp_ant),
        .smp_rssi  (smp_rssi),
        .floor_a0  (floor_a0),
        .floor_a1  (floor_a1),
        .ed_flag   (ed_flag)
    );

    // Squelch: when enabled, acquisition waits for energy detect.
    assign acq_allow = cfg.squelch_en ? ed_flag : 1'b1;

    AST_FLOORS_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> ($stable(floor_a0) && $stable(floor_a1))); // R8
    AST_SQUELCH_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (!ed_flag && acq_allow) |-> !cfg.squelch_en); // R9
endmodule

// File: tb/nf_energy_detect_bench.sv
module nf_energy_detect_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [1:0] cfg_addr = '0;
    logic [7:0] cfg_wdata = '0;
    logic       rx_en = 1'b0;
    logic       smp_valid = 1'b0;
    logic       smp_ant = 1'b0;
    logic       smp_sig = 1'b0;
    logic [7:0] smp_rssi = '0;
    logic       ed_flag, acq_allow;
    logic [7:0] floor_a0, floor_a1;

    int n_checks = 0;
    int n_fail = 0;

    // Bench model state
    int q [2][256];
    int cnt [2];
    int wp [2];
    int m_abs = 0, m_margin = 0, m_rel = 0, m_sq = 0;
    int m_ed = 0;

    always #5 clk = ~clk;

    nf_energy_detect u_nf_energy_detect (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .rx_en(rx_en), .smp_valid(smp_valid),
        .smp_ant(smp_ant), .smp_sig(smp_sig), .smp_rssi(smp_rssi),
        .ed_flag(ed_flag), .acq_allow(acq_allow),
        .floor_a0(floor_a0), .floor_a1(floor_a1)
    );

    function automatic int model_floor(input int a);
        int s, k, n, f;
        n = cnt[a];
        if (n == 0) return 0;
        s = 0;
        for (int i = 0; i < n; i++) s += q[a][i];
        k = 0;
        while ((2 << k) <= n) k++;
        f = s >> k;
        return (f > 255) ? 255 : f;
    endfunction

    function automatic int model_thr(input int a);
        int t;
        if (m_rel == 0) return m_abs;
        t = model_floor(a) + m_margin;
        return (t > 255) ? 255 : t;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic check_outputs(input string req);
        check({req, " ed_flag"}, int'(ed_flag), m_ed);
        check({req, " acq_allow R9"}, int'(acq_allow), (m_sq != 0) ? m_ed : 1);
        check({req, " floor_a0"}, int'(floor_a0), model_floor(0));
        check({req, " floor_a1"}, int'(floor_a1), model_floor(1));
    endtask

    task automatic cfg_write(input int addr, input int data);
        cfg_we = 1'b1; cfg_addr = 2'(addr); cfg_wdata = 8'(data);
        @(negedge clk);
        cfg_we = 1'b0;
        case (addr)
            0: m_abs = data;
            1: m_margin = data;
            2: begin m_rel = data & 1; m_sq = (data >> 1) & 1; end
            default: ;
        endcase
    endtask

    task automatic sample(input int a, input int sig, input int r, input string req);
        smp_valid = 1'b1; smp_ant = 1'(a); smp_sig = 1'(sig); smp_rssi = 8'(r);
        if (rx_en) begin
            m_ed = (r >= model_thr(a)) ? 1 : 0;
            if (sig == 0) begin
                if (cnt[a] < 256) begin q[a][cnt[a]] = r; cnt[a]++; end
                else begin q[a][wp[a]] = r; wp[a] = (wp[a] + 1) % 256; end
            end
        end else begin
            m_ed = 0;
        end
        @(negedge clk);
        smp_valid = 1'b0;
        check_outputs(req);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        int seed;
        seed = 7;
        void'($urandom(seed));
        cnt[0] = 0; cnt[1] = 0; wp[0] = 0; wp[1] = 0;
        repeat (3) @(negedge clk);
        check_outputs("R1 reset");
        rst_n = 1'b1;
        rx_en = 1'b1;
        @(negedge clk);

        // R3 absolute threshold, exact boundary
        cfg_write(0, 100);
        sample(0, 1, 100, "R3 R2 equal");
        sample(0, 1, 99, "R3 R2 below");
        sample(1, 1, 101, "R3 above");
        // R2 hold between strobes
        repeat (3) @(negedge clk);
        check("R2 hold", int'(ed_flag), m_ed);

        // R7 partial fill: three samples of 10 on antenna 0
        sample(0, 0, 10, "R7 n1");
        sample(0, 0, 10, "R7 n2");
        sample(0, 0, 10, "R7 n3");
        // R5 signal-present samples and other antenna untouched
        sample(0, 1, 200, "R5 sig ignored");
        sample(1, 0, 40, "R5 other antenna");

        // R4 relative mode with saturation
        cfg_write(2, 1);
        cfg_write(1, 250);
        sample(0, 1, 255, "R4 saturate hit");
        sample(0, 1, 254, "R4 saturate miss");
        cfg_write(1, 6);
        sample(0, 1, 21, "R4 floor plus margin");

        // R10 address 3 ignored
        cfg_write(3, 8'hFF);
        sample(1, 1, 45, "R10 addr3 no effect");
        check("R10 squelch unchanged", int'(acq_allow), 1);

        // R9 squelch
        cfg_write(2, 3);
        sample(0, 1, 0, "R9 squelch low");
        sample(0, 1, 255, "R9 squelch high");

        // R8 receiver disable keeps floors, clears flag
        rx_en = 1'b0;
        sample(0, 0, 255, "R8 disabled sample");
        sample(1, 0, 255, "R8 disabled sample");
        repeat (2) @(negedge clk);
        check_outputs("R8 hold");
        rx_en = 1'b1;

        // R6 R7 random fill past 256 on both antennas, mixed modes
        for (int i = 0; i < 1400; i++) begin
            int a, s, r;
            a = int'($urandom_range(0, 1));
            s = ($urandom_range(0, 3) == 0) ? 1 : 0;
            r = (a == 0) ? int'($urandom_range(20, 60)) : int'($urandom_range(0, 255));
            if (i % 200 == 0) cfg_write(2, int'($urandom_range(0, 3)));
            if (i % 150 == 0) cfg_write(1, int'($urandom_range(0, 40)));
            if (i % 170 == 0) cfg_write(0, int'($urandom_range(0, 255)));
            sample(a, s, r, (cnt[a] >= 256) ? "R6 R2 random" : "R7 R2 random");
        end

        // R6 directed: flood antenna 0 with a constant
        for (int i = 0; i < 256; i++) sample(0, 0, 77, "R6 flood");
        check("R6 mean", int'(floor_a0), 77);

        rst_n = 1'b0;
        @(negedge clk);
        m_ed = 0; m_abs = 0; m_margin = 0; m_rel = 0; m_sq = 0;
        cnt[0] = 0; cnt[1] = 0; wp[0] = 0; wp[1] = 0;
        check_outputs("R1 second reset");

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule